// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-side control logic of a legacy expansion-bus plug-and-play card. The bus decode is reduced to three strobes: a write to the fixed index port (I/O 0x279), a write to the fixed write-data port (I/O 0xA79), and a read of the card's relocatable read-data port. Software first writes a register index to the index port and then moves data through the data port. The block tracks the card's lifecycle through four states: waiting for the key, sleeping, isolating and configuring. It also holds the card select number (CSN), the read-port address and the selected logical device.

After reset the card ignores all register traffic until it has seen the initiation key on the index port. Software then uses the Wake command to bring a sleeping card into isolation or configuration. While the card is isolating it arbitrates serially on its identity bits against the other cards on the bus. The winner receives a CSN. Software commands on the write-only control register reset the logical devices, clear the CSN or send the card back to waiting for the key. The command bits take effect as pulses and are not stored.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset the state is wait-for-key (state code 0), CSN is 0, the logical device is 0, the read-port address is 0, and both pulse outputs are low.
- R2: In wait-for-key, index-port writes are compared with a KEY_LEN-byte key. The key starts at 0x6A, and each next byte is the previous one shifted right by one, with bit 7 set to bit0 XOR bit1 of the previous byte. State becomes sleep (code 1) in the cycle after the last key byte. A byte that does not match restarts the match from the first byte.
- R3: In wait-for-key, data-port writes change no register and reads are never driven.
- R4: A data write to index 0x00 sets the read-port address to the written byte shifted left by two (bits [9:2]). A read at index 0x00 is not driven.
- R5: Bit 0 of a write to index 0x02 produces a dev_reset_o pulse of exactly one cycle and returns the logical device to 0. CSN and state are kept.
- R6: Bit 1 of a write to index 0x02 returns the card to wait-for-key with the CSN kept. Leaving that state again needs the full key.
- R7: Bit 2 of a write to index 0x02 clears the CSN to 0 without changing state.
- R8: A write to index 0x03 (Wake) acts only in sleep and only when the byte equals the CSN. A byte of 0 enters isolation (code 2) and a non-zero byte enters config (code 3). The same edge produces a one-cycle ptr_reset_o pulse. Any other Wake changes nothing and gives no pulse.
- R9: In isolation, each read at index 0x01 drives 0x55 if the current identity bit is 1 and 0x00 if it is 0. Identity bits go LSB first. If the card's bit is 0 while iso_bus_bit is 1, the card returns to sleep. After ID_BITS reads without a loss the card has won and stops driving these reads.
- R10: Index 0x06 holds the CSN. In config it is read and written. In isolation a write is accepted only after the card has won, and the write moves the card to config.
- R11: Index 0x07 selects the logical device in config only, and writes of values of NUM_LDN or above are ignored. With NUM_LDN = 1 it always reads 0 and ignores writes.
- R12: rd_drive is high only during rd_strobe, and only for index 0x06 or 0x07 in config or for index 0x01 in isolation before the win. rdata is 0 whenever rd_drive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr | input | 1 | Write strobe for the index port |
| data_wr | input | 1 | Write strobe for the write-data port |
| rd_strobe | input | 1 | Read strobe for the read-data port |
| wdata | input | 8 | Byte written on either port |
| iso_bus_bit | input | 1 | Bus value seen during an isolation read |
| rdata | output | 8 | Read data for the current index |
| rd_drive | output | 1 | Card drives the read-data port |
| state_o | output | 2 | Card state: 0 key wait, 1 sleep, 2 isolation, 3 config |
| csn_o | output | 8 | Card select number |
| ldn_o | output | 8 | Selected logical device |
| rd_port_o | output | 10 | Read-port I/O address |
| dev_reset_o | output | 1 | One-cycle logical-device reset pulse |
| ptr_reset_o | output | 1 | One-cycle resource-pointer reset pulse |

## Verification
The bench breaks the key after three correct bytes. A matcher that resumes instead of restarting would then reach sleep early. It sends Wake with a mismatching CSN and again while already in config. A design that skips the state or CSN gate would move the card or pulse the pointer reset. In isolation the bench makes the card lose on a 0 bit and then restarts the arbitration. A counter that is not cleared would drive the wrong first bit. It also writes a CSN before the win, which a loose design would accept. Finally it checks that each control bit acts alone and only for one cycle: a sticky bit would keep dev_reset_o high, and a crossed bit would disturb the CSN or the state.

// File: rtl/pnp_pkg.sv
package pnp_pkg;

    typedef enum logic [1:0] {
        ST_WFK   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_ISO   = 2'd2,
        ST_CFG   = 2'd3
    } card_state_e;

    localparam logic [7:0] IDX_RDPORT = 8'h00;
    localparam logic [7:0] IDX_SERIAL = 8'h01;
    localparam logic [7:0] IDX_CTRL   = 8'h02;
    localparam logic [7:0] IDX_WAKE   = 8'h03;
    localparam logic [7:0] IDX_CSN    = 8'h06;
    localparam logic [7:0] IDX_LDN    = 8'h07;

    typedef struct packed {
        card_state_e st;
        logic [7:0]  idx;
        logic [7:0]  csn;
        logic [7:0]  ldn;
        logic [9:0]  rdport;
        logic        dev_rst;
        logic        ptr_rst;
    } ctl_regs_t;

    // One step of the initiation-key generator
    function automatic logic [7:0] key_next(input logic [7:0] cur);
        return {cur[1] ^ cur[0], cur[7:1]};
    endfunction

endpackage

// File: rtl/pnp_key_match.sv
module pnp_key_match #(
    parameter int         KEY_LEN  = 8,
    parameter logic [7:0] KEY_SEED = 8'h6A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic       addr_wr,
    input  logic [7:0] wdata,
    output logic       key_done
);
    import pnp_pkg::*;

    localparam int CW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

    logic [7:0]    exp_d, exp_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          hit;

    assign hit      = armed && addr_wr && (wdata == exp_q);
    assign key_done = hit && (cnt_q == LAST);

    always_comb begin
        exp_d = exp_q;
        cnt_d = cnt_q;
        if (!armed || key_done || (addr_wr && !hit)) begin
            exp_d = KEY_SEED;
            cnt_d = '0;
        end else if (hit) begin
            exp_d = key_next(exp_q);
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= KEY_SEED;
            cnt_q <= '0;
        end else begin
            exp_q <= exp_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pnp_isolate.sv
module pnp_isolate #(
    parameter int                  ID_BITS = 16,
    parameter logic [ID_BITS-1:0]  CARD_ID = 16'hA5C3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sample,
    input  logic bus_bit,
    output logic my_bit,
    output logic lost,
    output logic won
);
    localparam int IW = (ID_BITS > 1) ? $clog2(ID_BITS) : 1;
    localparam logic [IW-1:0] LAST = IW'(ID_BITS - 1);

    logic [IW-1:0] pos_d, pos_q;
    logic          won_d, won_q;

    assign my_bit = CARD_ID[pos_q];
    assign lost   = sample && !won_q && !my_bit && bus_bit;
    assign won    = won_q;

    always_comb begin
        pos_d = pos_q;
        won_d = won_q;
        if (start) begin
            pos_d = '0;
            won_d = 1'b0;
        end else if (sample && !won_q && !lost) begin
            if (pos_q == LAST) won_d = 1'b1;
            else               pos_d = pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            won_q <= 1'b0;
        end else begin
            pos_q <= pos_d;
            won_q <= won_d;
        end
    end

endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl #(
    parameter int                 KEY_LEN = 8,
    parameter int                 ID_BITS = 16,
    parameter logic [ID_BITS-1:0] CARD_ID = 16'hA5C3,
    parameter int                 NUM_LDN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_wr,
    input  logic       data_wr,
    input  logic       rd_strobe,
    input  logic [7:0] wdata,
    input  logic       iso_bus_bit,
    output logic [7:0] rdata,
    output logic       rd_drive,
    output logic [1:0] state_o,
    output logic [7:0] csn_o,
    output logic [7:0] ldn_o,
    output logic [9:0] rd_port_o,
    output logic       dev_reset_o,
    output logic       ptr_reset_o
);
    import pnp_pkg::*;

    localparam bit MULTI_LDN = (NUM_LDN > 1);

    ctl_regs_t r_d, r_q;
    logic key_done, iso_start, iso_sample, iso_bit, iso_lost, iso_won;
    logic wake_hit;
    logic [7:0] ldn_view, rd_val;

    pnp_key_match #(.KEY_LEN(KEY_LEN), .KEY_SEED(8'h6A)) u_key (
        .clk(clk), .rst_n(rst_n),
        .armed(r_q.st == ST_WFK),
        .addr_wr(addr_wr), .wdata(wdata),
        .key_done(key_done)
    );

    pnp_isolate #(.ID_BITS(ID_BITS), .CARD_ID(CARD_ID)) u_iso (
        .clk(clk), .rst_n(rst_n),
        .start(iso_start), .sample(iso_sample), .bus_bit(iso_bus_bit),
        .my_bit(iso_bit), .lost(iso_lost), .won(iso_won)
    );

    assign wake_hit   = data_wr && (r_q.idx == IDX_WAKE) &&
                        (r_q.st == ST_SLEEP) && (wdata == r_q.csn);
    assign iso_start  = wake_hit && (wdata == 8'h00);
    assign iso_sample = rd_strobe && (r_q.st == ST_ISO) && (r_q.idx == IDX_SERIAL);

    generate
        if (MULTI_LDN) begin : g_multi
            assign ldn_view = r_q.ldn;
        end else begin : g_single
            assign ldn_view = 8'h00;
        end
    endgenerate

    always_comb begin
        r_d         = r_q;
        r_d.dev_rst = 1'b0;
        r_d.ptr_rst = 1'b0;
        if (r_q.st == ST_WFK) begin
            if (key_done) r_d.st = ST_SLEEP;
        end else begin
            if (addr_wr) r_d.idx = wdata;
            if (data_wr) begin
                case (r_q.idx)
                    IDX_RDPORT: r_d.rdport = {wdata, 2'b00};
                    IDX_CTRL: begin
                        if (wdata[0]) begin
                            r_d.dev_rst = 1'b1;
                            r_d.ldn     = 8'h00;
                        end
                        if (wdata[1]) r_d.st  = ST_WFK;
                        if (wdata[2]) r_d.csn = 8'h00;
                    end
                    IDX_WAKE: begin
                        if (wake_hit) begin
                            r_d.st      = (wdata == 8'h00) ? ST_ISO : ST_CFG;
                            r_d.ptr_rst = 1'b1;
                        end
                    end
                    IDX_CSN: begin
                        if (r_q.st == ST_CFG) begin
                            r_d.csn = wdata;
                        end else if (r_q.st == ST_ISO && iso_won) begin
                            r_d.csn = wdata;
                            r_d.st  = ST_CFG;
                        end
                    end
                    IDX_LDN: begin
                        if (MULTI_LDN && r_q.st == ST_CFG &&
                            ({24'd0, wdata} < NUM_LDN))
                            r_d.ldn = wdata;
                    end
                    default: ;
                endcase
            end
            if (iso_lost) r_d.st = ST_SLEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_WFK, idx: 8'h00, csn: 8'h00, ldn: 8'h00,
                     rdport: 10'h000, dev_rst: 1'b0, ptr_rst: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_val   = 8'h00;
        rd_drive = 1'b0;
        if (rd_strobe) begin
            if (r_q.st == ST_ISO && r_q.idx == IDX_SERIAL && !iso_won) begin
                rd_drive = 1'b1;
                rd_val   = iso_bit ? 8'h55 : 8'h00;
            end else if (r_q.st == ST_CFG && r_q.idx == IDX_CSN) begin
                rd_drive = 1'b1;
                rd_val   = r_q.csn;
            end else if (r_q.st == ST_CFG && r_q.idx == IDX_LDN) begin
                rd_drive = 1'b1;
                rd_val   = ldn_view;
            end
        end
    end

    assign rdata       = rd_val;
    assign state_o     = r_q.st;
    assign csn_o       = r_q.csn;
    assign ldn_o       = ldn_view;
    assign rd_port_o   = r_q.rdport;
    assign dev_reset_o = r_q.dev_rst;
    assign ptr_reset_o = r_q.ptr_rst;

endmodule

// File: rtl/pnp_card_ctrl_chk.sv
module pnp_card_ctrl_chk #(
    parameter int NUM_LDN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_strobe,
    input logic [7:0] rdata,
    input logic       rd_drive,
    input logic [1:0] state_o,
    input logic [7:0] csn_o,
    input logic [7:0] ldn_o,
    input logic       dev_reset_o,
    input logic       ptr_reset_o
);
    p_dev_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset_o |=> !dev_reset_o);

    p_ptr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_reset_o |=> !ptr_reset_o);

    p_ptr_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_reset_o |-> (state_o == 2'd2 || state_o == 2'd3));

    p_key_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 2'd0 && state_o != 2'd0) |-> state_o == 2'd1);

    p_wfk_csn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 2'd0 && state_o == 2'd0) |-> $stable(csn_o));

    p_ldn_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ({24'd0, ldn_o} < NUM_LDN));

    p_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> rd_strobe);

    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> rdata == 8'h00);

endmodule

bind pnp_card_ctrl pnp_card_ctrl_chk #(.NUM_LDN(NUM_LDN)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rdata(rdata),
    .rd_drive(rd_drive), .state_o(state_o), .csn_o(csn_o), .ldn_o(ldn_o),
    .dev_reset_o(dev_reset_o), .ptr_reset_o(ptr_reset_o)
);

// File: tb/sim_pnp_card_ctrl.sv
module sim_pnp_card_ctrl;
    localparam int          CLK_P   = 10;
    localparam int          KEY_LEN = 8;
    localparam int          ID_BITS = 16;
    localparam logic [15:0] ID      = 16'hA5C3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic addr_wr = 0, data_wr = 0, rd_strobe = 0, iso_bus_bit = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata, csn, ldn, rdata1, csn1, ldn1;
    logic       rd_drive, dres, pres, rd_drive1, dres1, pres1;
    logic [1:0] st, st1;
    logic [9:0] rport, rport1;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    pnp_card_ctrl #(.KEY_LEN(KEY_LEN), .ID_BITS(ID_BITS), .CARD_ID(ID), .NUM_LDN(4)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr),
        .rd_strobe(rd_strobe), .wdata(wdata), .iso_bus_bit(iso_bus_bit),
        .rdata(rdata), .rd_drive(rd_drive), .state_o(st), .csn_o(csn),
        .ldn_o(ldn), .rd_port_o(rport), .dev_reset_o(dres), .ptr_reset_o(pres));

    pnp_card_ctrl #(.KEY_LEN(KEY_LEN), .ID_BITS(ID_BITS), .CARD_ID(ID), .NUM_LDN(1)) u1 (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr),
        .rd_strobe(rd_strobe), .wdata(wdata), .iso_bus_bit(iso_bus_bit),
        .rdata(rdata1), .rd_drive(rd_drive1), .state_o(st1), .csn_o(csn1),
        .ldn_o(ldn1), .rd_port_o(rport1), .dev_reset_o(dres1), .ptr_reset_o(pres1));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wr_addr(input logic [7:0] b);
        @(negedge clk); addr_wr = 1; wdata = b;
        @(negedge clk); addr_wr = 0;
    endtask

    task automatic wr_data(input logic [7:0] b);
        @(negedge clk); data_wr = 1; wdata = b;
        @(negedge clk); data_wr = 0;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] b);
        wr_addr(i); wr_data(b);
    endtask

    // Read strobe for one cycle; outputs captured before the edge
    task automatic rd(input logic bus, output logic [7:0] v, output logic drv);
        @(negedge clk); rd_strobe = 1; iso_bus_bit = bus;
        #1; v = rdata; drv = rd_drive;
        @(negedge clk); rd_strobe = 0; iso_bus_bit = 0;
    endtask

    function automatic logic [7:0] knext(input logic [7:0] c);
        return {c[1] ^ c[0], c[7:1]};
    endfunction

    task automatic send_key(input int upto);
        logic [7:0] k = 8'h6A;
        for (int i = 0; i < upto; i++) begin
            wr_addr(k);
            k = knext(k);
        end
    endtask

    task automatic t_reset;
        chk_eq("R1 state", st, 0);
        chk_eq("R1 csn", csn, 0);
        chk_eq("R1 ldn", ldn, 0);
        chk_eq("R1 rdport", rport, 0);
        chk_eq("R1 pulses", {dres, pres}, 0);
    endtask

    task automatic t_wfk_ignore;
        logic [7:0] v; logic d;
        wr_addr(8'h06); wr_data(8'h33);
        chk_eq("R3 csn held", csn, 0);
        chk_eq("R3 state", st, 0);
        rd(1'b0, v, d);
        chk_eq("R3 no drive", d, 0);
    endtask

    task automatic t_key;
        send_key(3); wr_addr(8'h00);
        send_key(KEY_LEN - 1);
        chk_eq("R2 restart needs full key", st, 0);
        wr_addr(8'h6A);
        send_key(0);
        // Restart: resend whole key
        send_key(KEY_LEN);
        chk_eq("R2 sleep after key", st, 1);
    endtask

    task automatic t_wake_miss;
        reg_wr(8'h03, 8'h05);
        chk_eq("R8 wake csn mismatch state", st, 1);
        chk_eq("R8 no pulse", pres, 0);
    endtask

    task automatic t_rdport;
        logic [7:0] v; logic d;
        reg_wr(8'h00, 8'h9C);
        chk_eq("R4 read port", rport, 10'h270);
        rd(1'b0, v, d);
        chk_eq("R4 idx0 read not driven", d, 0);
    endtask

    task automatic t_isolation;
        logic [7:0] v; logic d;
        reg_wr(8'h03, 8'h00);
        chk_eq("R8 wake 0 to isolation", st, 2);
        chk_eq("R8 ptr pulse", pres, 1);
        @(negedge clk);
        chk_eq("R8 ptr pulse one cycle", pres, 0);
        wr_addr(8'h01);
        // bits 0,1 are 1, bit 2 is 0: lose on bit 2 with bus 1
        for (int i = 0; i < 3; i++) begin
            rd(1'b1, v, d);
            chk_eq("R9 serial data", v, ID[i] ? 8'h55 : 8'h00);
        end
        chk_eq("R9 loser sleeps", st, 1);
        reg_wr(8'h03, 8'h00);
        chk_eq("R9 back to isolation", st, 2);
        reg_wr(8'h06, 8'h07);
        chk_eq("R10 csn before win ignored", csn, 0);
        chk_eq("R10 stays isolating", st, 2);
        wr_addr(8'h01);
        for (int i = 0; i < ID_BITS; i++) begin
            rd(ID[i], v, d);
            chk(v == (ID[i] ? 8'h55 : 8'h00) && d, "R9 serial bit", v, ID[i] ? 8'h55 : 8'h00);
        end
        chk_eq("R9 winner stays", st, 2);
        rd(1'b0, v, d);
        chk_eq("R12 winner not driving", d, 0);
        reg_wr(8'h06, 8'h05);
        chk_eq("R10 csn assigned", csn, 5);
        chk_eq("R10 to config", st, 3);
    endtask

    task automatic t_config;
        logic [7:0] v; logic d;
        wr_addr(8'h06);
        rd(1'b0, v, d);
        chk(d && v == 8'h05, "R10 csn readback", v, 5);
        reg_wr(8'h07, 8'h02);
        chk_eq("R11 ldn write", ldn, 2);
        wr_data(8'h09);
        chk_eq("R11 ldn out of range ignored", ldn, 2);
        chk_eq("R11 single device ldn", ldn1, 0);
        rd(1'b0, v, d);
        chk(d && v == 8'h02, "R12 ldn readback", v, 2);
        chk_eq("R11 single device reads 0", rdata1, 0);
    endtask

    task automatic t_ctrl;
        reg_wr(8'h02, 8'h01);
        chk_eq("R5 dev reset pulse", dres, 1);
        chk_eq("R5 ldn cleared", ldn, 0);
        chk_eq("R5 csn kept", csn, 5);
        chk_eq("R5 state kept", st, 3);
        @(negedge clk);
        chk_eq("R5 pulse not sticky", dres, 0);
        wr_data(8'h04);
        chk_eq("R7 csn cleared", csn, 0);
        chk_eq("R7 state kept", st, 3);
        reg_wr(8'h06, 8'h05);
        reg_wr(8'h02, 8'h02);
        chk_eq("R6 to key wait", st, 0);
        chk_eq("R6 csn kept", csn, 5);
        chk_eq("R6 no dev reset", dres, 0);
        wr_data(8'h00);
        chk_eq("R6 still waiting", st, 0);
        send_key(KEY_LEN);
        chk_eq("R6 key again to sleep", st, 1);
        reg_wr(8'h03, 8'h05);
        chk_eq("R8 wake nonzero to config", st, 3);
        chk_eq("R8 ptr pulse config", pres, 1);
        wr_data(8'h05);
        chk_eq("R8 wake outside sleep no pulse", pres, 0);
        chk_eq("R8 wake outside sleep state", st, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wfk_ignore();
        t_key();
        t_wake_miss();
        t_rdport();
        t_isolation();
        t_config();
        t_ctrl();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule